// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits between the switch fabric's CPU-port output and system memory. When a frame starts to arrive, it reads the control word of the descriptor that its ring pointer selects. If software has handed that descriptor over, the block reads the buffer length and streams the frame into the buffer as 32-bit words with byte enables. It then writes a status word and finally hands the descriptor back to software by rewriting the control word with the ownership flag cleared. If software still holds the descriptor, the frame is drained without any memory traffic and an error pulse reports that no descriptor was available.

A descriptor is four consecutive 32-bit words. Word 0 is the control word: bit 31 means the hardware owns the descriptor, bit 28 marks the last descriptor of the ring, and bits 24:0 hold the buffer byte address, which must be word aligned. Word 1 is unused. The low 11 bits of word 2 hold the buffer length. Word 3 receives the status. The memory port addresses 32-bit words, and descriptor n starts at word `ring_base + 4*n`. The memory returns read data one cycle after the read request.

Top module: `rx_ring_writer`

## Requirements
- R1: The block writes no buffer word or status word for a descriptor unless bit 31 of that descriptor's word 0 was read as 1 for the current frame.
- R2: After a frame completes in a descriptor whose word 0 has bit 28 set, the next frame goes to the descriptor at `ring_base`. Otherwise it goes to the next descriptor, four words further on, and bit 28 is kept in the released word 0.
- R3: The usable buffer size is the low 11 bits of word 2, capped at 1550 bytes.
- R4: The status word is laid out as follows: bits 26:16 hold the length, bits 14:12 the source port, bits 5:4 the address class, bit 3 the IP checksum failure, bit 2 VLAN-tag presence and bits 1:0 the packet type (0 = IP, 1 = PPPoE). All other bits are 0. The side information is taken from the last beat.
- R5: The reported length counts every byte delivered on the stream, including the 4 trailing checksum bytes. Frame byte k is written to buffer byte k, little-endian within each word.
- R6: A frame longer than the usable size is truncated. No byte at or beyond the usable size is written, and the reported length equals the usable size.
- R7: If bit 31 of word 0 reads as 0, `rx_err` pulses once, the whole frame is accepted and discarded with no memory write, and the ring pointer stays on the same descriptor.
- R8: The status word is written in the cycle directly before word 0 is rewritten with bit 31 cleared and the address and bit 28 unchanged. `rx_done` pulses in the cycle of that final write.
- R9: During and after reset `in_ready`, `mem_req`, `rx_done` and `rx_err` are low, and the ring pointer selects `ring_base`.
- R10: `in_nbytes` gives the number of valid bytes on a last beat (0 encodes 4). Non-last beats carry 4 bytes. Byte enables cover only the valid bytes that fit, so buffer bytes past the frame end keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Word address of descriptor 0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| in_valid | input | 1 | Frame beat valid |
| in_ready | output | 1 | Beat accepted when high with in_valid |
| in_data | input | 32 | Frame bytes, first byte in bits 7:0 |
| in_last | input | 1 | Last beat of the frame |
| in_nbytes | input | 2 | Valid bytes on the last beat, 0 = 4 |
| in_src_port | input | 3 | Source port number |
| in_pkt_type | input | 2 | Packet type code |
| in_csum_bad | input | 1 | IP checksum failed |
| in_vlan | input | 1 | VLAN tag was present |
| in_addr_class | input | 2 | Destination address class |
| rx_done | output | 1 | Pulse when a descriptor is returned to software |
| rx_err | output | 1 | Pulse when a frame finds no owned descriptor |

## Verification
The hardest cases to reach from the ports are a frame dropped on a software-held descriptor followed by a resumed ring, and a clamp that cuts a word in the middle. The bench's memory model lets the stimulus leave one descriptor unarmed, check that its buffer and status stay untouched, re-arm it and confirm that the next frame lands in that same slot. Buffers are pre-filled with a marker byte, and frames are sized so that the clamp and the final partial beat each end inside a word; the filler bytes in the unused lanes must not appear in memory. A fifth frame after a full lap checks the wrap on bit 28.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 28;
  localparam int LEN_W    = 11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OWN, ST_LEN, ST_DATA, ST_STAT, ST_REL, ST_DROP
  } wr_state_e;

  typedef struct packed {
    logic [2:0] src;
    logic [1:0] cls;
    logic       csum_bad;
    logic       vlan;
    logic [1:0] ptype;
  } side_t;

  // usable buffer size: length field capped at the hardware maximum
  function automatic logic [LEN_W-1:0] eff_limit(input logic [31:0] lenword,
                                                 input int unsigned cap);
    logic [LEN_W-1:0] f;
    f = lenword[LEN_W-1:0];
    return (f > LEN_W'(cap)) ? LEN_W'(cap) : f;
  endfunction

  // contiguous low-lane byte enable for n bytes (0..4)
  function automatic logic [3:0] lane_mask(input logic [2:0] n);
    logic [3:0] m;
    case (n)
      3'd0:    m = 4'b0000;
      3'd1:    m = 4'b0001;
      3'd2:    m = 4'b0011;
      3'd3:    m = 4'b0111;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len,
                                              input side_t s);
    logic [31:0] w;
    w        = '0;
    w[26:16] = len;
    w[14:12] = s.src;
    w[5:4]   = s.cls;
    w[3]     = s.csum_bad;
    w[2]     = s.vlan;
    w[1:0]   = s.ptype;
    return w;
  endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW    = 23,
  parameter int IDX_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          advance,
  input  logic          wrap,
  output logic [IDX_W-1:0] idx,
  output logic [AW-1:0] desc_addr
);
  localparam int DESC_WORDS_LOG2 = 2;

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (advance) idx <= wrap ? '0 : idx + 1'b1;
  end

  assign desc_addr = ring_base + (AW'(idx) << DESC_WORDS_LOG2);
endmodule

// File: rtl/rxr_byte_track.sv
module rxr_byte_track
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             beat,
  input  logic             last,
  input  logic [1:0]       nbytes,
  input  logic [LEN_W-1:0] limit,
  output logic [LEN_W-1:0] cnt,
  output logic [3:0]       be,
  output logic             wr_en
);
  logic [2:0]       beat_n;
  logic [LEN_W-1:0] room;
  logic [2:0]       take;

  always_comb begin
    beat_n = (last && nbytes != 2'd0) ? {1'b0, nbytes} : 3'd4;
    room   = limit - cnt;
    take   = (room < LEN_W'(beat_n)) ? room[2:0] : beat_n;
    be     = lane_mask(take);
    wr_en  = (take != 3'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (beat)       cnt <= cnt + LEN_W'(take);
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int AW      = 23,
  parameter int IDX_W   = 10,
  parameter int MAX_LEN = 1550
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic [31:0]   mem_rdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  input  logic          in_last,
  input  logic [1:0]    in_nbytes,
  input  logic [2:0]    in_src_port,
  input  logic [1:0]    in_pkt_type,
  input  logic          in_csum_bad,
  input  logic          in_vlan,
  input  logic [1:0]    in_addr_class,
  output logic          rx_done,
  output logic          rx_err
);
  localparam logic [AW-1:0] OFS_LEN  = AW'(2);
  localparam logic [AW-1:0] OFS_STAT = AW'(3);

  wr_state_e        st, st_nx;
  logic [31:0]      w0_q;
  logic [LEN_W-1:0] lim_q;
  side_t            side_q;
  logic             own_ok;

  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    desc_addr;
  logic [AW-1:0]    buf_base;
  logic [LEN_W-1:0] byte_cnt;
  logic [3:0]       trk_be;
  logic             trk_wr;

  // named internal events for the checker
  logic ev_data_wr, ev_stat_wr, ev_rel_wr, ev_drop_busy, ev_beat;

  assign buf_base = AW'(w0_q[24:2]);
  assign ev_beat  = (st == ST_DATA) && in_valid;

  rxr_ring_ptr #(.AW(AW), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
    .advance(ev_rel_wr), .wrap(w0_q[LAST_BIT]),
    .idx(idx), .desc_addr(desc_addr)
  );

  rxr_byte_track u_trk (
    .clk(clk), .rst_n(rst_n), .clear(st == ST_LEN), .beat(ev_beat),
    .last(in_last), .nbytes(in_nbytes), .limit(lim_q),
    .cnt(byte_cnt), .be(trk_be), .wr_en(trk_wr)
  );

  always_comb begin
    st_nx        = st;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = desc_addr;
    mem_wdata    = '0;
    mem_be       = '0;
    in_ready     = 1'b0;
    rx_done      = 1'b0;
    rx_err       = 1'b0;
    ev_data_wr   = 1'b0;
    ev_stat_wr   = 1'b0;
    ev_rel_wr    = 1'b0;
    ev_drop_busy = 1'b0;
    case (st)
      ST_IDLE: if (in_valid) begin
        mem_req = 1'b1;
        st_nx   = ST_OWN;
      end
      ST_OWN: if (mem_rdata[OWN_BIT]) begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + OFS_LEN;
        st_nx    = ST_LEN;
      end else begin
        rx_err = 1'b1;
        st_nx  = ST_DROP;
      end
      ST_LEN: st_nx = ST_DATA;
      ST_DATA: begin
        in_ready = 1'b1;
        if (in_valid) begin
          if (trk_wr) begin
            mem_req    = 1'b1;
            mem_we     = 1'b1;
            mem_addr   = buf_base + AW'(byte_cnt[LEN_W-1:2]);
            mem_wdata  = in_data;
            mem_be     = trk_be;
            ev_data_wr = 1'b1;
          end
          if (in_last) st_nx = ST_STAT;
        end
      end
      ST_STAT: begin
        mem_req    = 1'b1;
        mem_we     = 1'b1;
        mem_addr   = desc_addr + OFS_STAT;
        mem_wdata  = pack_status(byte_cnt, side_q);
        mem_be     = 4'hF;
        ev_stat_wr = 1'b1;
        st_nx      = ST_REL;
      end
      ST_REL: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = w0_q & ~(32'h1 << OWN_BIT);
        mem_be    = 4'hF;
        ev_rel_wr = 1'b1;
        rx_done   = 1'b1;
        st_nx     = ST_IDLE;
      end
      ST_DROP: begin
        in_ready     = 1'b1;
        ev_drop_busy = 1'b1;
        if (in_valid && in_last) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      w0_q   <= '0;
      lim_q  <= '0;
      side_q <= '0;
      own_ok <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == ST_OWN && mem_rdata[OWN_BIT]) begin
        w0_q   <= mem_rdata;
        own_ok <= 1'b1;
      end
      if (ev_rel_wr) own_ok <= 1'b0;
      if (st == ST_LEN) lim_q <= eff_limit(mem_rdata, MAX_LEN);
      if (ev_beat && in_last)
        side_q <= '{src: in_src_port, cls: in_addr_class, csum_bad: in_csum_bad,
                    vlan: in_vlan, ptype: in_pkt_type};
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int IDX_W = 10,
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_we,
  input logic             rx_done,
  input logic             rx_err,
  input logic             ev_data_wr,
  input logic             ev_stat_wr,
  input logic             ev_rel_wr,
  input logic             ev_drop_busy,
  input logic             own_ok,
  input logic             rel_last,
  input logic [IDX_W-1:0] idx,
  input logic [LEN_W-1:0] byte_cnt,
  input logic [LEN_W-1:0] byte_lim
);
  assert_owned_before_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_wr || ev_stat_wr) |-> own_ok);

  assert_wrap_to_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rel_last) |=> (idx == '0));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_wr |-> (byte_cnt < byte_lim));

  assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop_busy |-> !mem_we);

  assert_drop_keeps_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> $stable(idx));

  assert_single_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_done, rx_err}));

  assert_status_then_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_wr |=> ev_rel_wr);

  assert_release_after_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rel_wr |-> $past(ev_stat_wr));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.IDX_W(IDX_W), .LEN_W(rxr_pkg::LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .rx_done(rx_done), .rx_err(rx_err),
  .ev_data_wr(ev_data_wr), .ev_stat_wr(ev_stat_wr), .ev_rel_wr(ev_rel_wr),
  .ev_drop_busy(ev_drop_busy), .own_ok(own_ok), .rel_last(w0_q[rxr_pkg::LAST_BIT]),
  .idx(idx), .byte_cnt(byte_cnt), .byte_lim(lim_q)
);

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
  localparam int AW   = 23;
  localparam int RING = 'h100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ring_base;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [3:0]    mem_be;
  logic          in_valid, in_ready, in_last, in_csum_bad, in_vlan;
  logic [31:0]   in_data;
  logic [1:0]    in_nbytes, in_pkt_type, in_addr_class;
  logic [2:0]    in_src_port;
  logic          rx_done, rx_err;

  rx_ring_writer dut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_nbytes(in_nbytes), .in_src_port(in_src_port),
    .in_pkt_type(in_pkt_type), .in_csum_bad(in_csum_bad), .in_vlan(in_vlan),
    .in_addr_class(in_addr_class), .rx_done(rx_done), .rx_err(rx_err)
  );

  always #4 clk = ~clk;

  // memory model with a backdoor port for the software side
  logic [31:0] mem [0:4095];
  logic        bd_we = 1'b0;
  logic [11:0] bd_addr = '0;
  logic [31:0] bd_data = '0;
  int cyc = 0;
  int stat_cyc [4] = '{default: -10};
  int rel_cyc  [4] = '{default: -20};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bd_we) mem[bd_addr] <= bd_data;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      if (int'(mem_addr) >= RING && int'(mem_addr) < RING + 16) begin
        if (mem_addr[1:0] == 2'd3) stat_cyc[(int'(mem_addr) - RING) / 4] <= cyc;
        if (mem_addr[1:0] == 2'd0) rel_cyc[(int'(mem_addr) - RING) / 4] <= cyc;
      end
    end
  end

  typedef struct {
    int          kind;   // 0 completed, 1 dropped, 2 probe of an unowned slot
    int          idx;
    int          len;
    logic [31:0] stat;
    logic [31:0] w0;
    int          seed;
  } exp_t;
  exp_t q[$];
  bit   drv_done = 1'b0;

  function automatic int buf_word(int i);
    return 'h200 + i * 'h200;
  endfunction

  task automatic bd(input int a, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = 12'(a); bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic arm(input int i, input int buflen, input int fillw, input bit own);
    for (int w = 0; w < fillw; w++) bd(buf_word(i) + w, 32'hEEEE_EEEE);
    bd(RING + i * 4 + 2, 32'(buflen));
    bd(RING + i * 4 + 3, 32'h0);
    bd(RING + i * 4, (own ? 32'h8000_0000 : 32'h0) | (i == 3 ? 32'h1000_0000 : 32'h0)
                     | 32'(buf_word(i) * 4));
  endtask

  task automatic send(input int seed, input int n, input int src, input int cls,
                      input bit cs, input bit vl, input int ty,
                      input int idx, input int len, input bit drop);
    exp_t e;
    int   nb;
    e.kind = drop ? 1 : 0;
    e.idx  = idx;
    e.len  = len;
    e.seed = seed;
    e.stat = (32'(len) << 16) | (32'(src) << 12) | (32'(cls) << 4)
           | (32'(cs) << 3) | (32'(vl) << 2) | 32'(ty);
    e.w0   = (idx == 3 ? 32'h1000_0000 : 32'h0) | 32'(buf_word(idx) * 4);
    q.push_back(e);
    nb = (n + 3) / 4;
    in_src_port = 3'(src); in_addr_class = 2'(cls);
    in_csum_bad = cs; in_vlan = vl; in_pkt_type = 2'(ty);
    for (int bt = 0; bt < nb; bt++) begin
      for (int j = 0; j < 4; j++)
        in_data[8*j +: 8] = (bt * 4 + j < n) ? 8'(seed + bt * 4 + j) : 8'h55;
      in_valid  = 1'b1;
      in_last   = (bt == nb - 1);
      in_nbytes = (bt == nb - 1) ? 2'(n % 4) : 2'd0;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // driver
  initial begin
    exp_t p;
    rst_n = 1'b0; ring_base = AW'(RING);
    in_valid = 1'b0; in_last = 1'b0; in_data = '0; in_nbytes = '0;
    in_src_port = '0; in_pkt_type = '0; in_csum_bad = 1'b0; in_vlan = 1'b0;
    in_addr_class = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    arm(0, 1550, 20, 1'b1);
    arm(1, 1550, 20, 1'b1);
    arm(2, 20, 12, 1'b1);
    arm(3, 2000, 404, 1'b1);
    send(8'h10, 64, 2, 1, 1'b0, 1'b1, 0, 0, 64, 1'b0);      // R4 R5
    send(8'h30, 61, 5, 3, 1'b1, 1'b0, 1, 1, 61, 1'b0);      // R10 partial last beat
    send(8'h70, 30, 1, 0, 1'b0, 1'b0, 0, 2, 20, 1'b0);      // R6 truncation
    send(8'h01, 1602, 7, 2, 1'b1, 1'b1, 1, 3, 1550, 1'b0);  // R3 cap
    arm(0, 1550, 20, 1'b1);
    send(8'hA0, 63, 4, 2, 1'b0, 1'b1, 1, 0, 63, 1'b0);      // R2 wrap
    arm(1, 1550, 20, 1'b0);
    send(8'hC0, 16, 3, 1, 1'b0, 1'b0, 0, 1, 0, 1'b1);       // R7 drop
    p.kind = 2; p.idx = 1; p.len = 0; p.stat = '0; p.w0 = '0; p.seed = 0;
    q.push_back(p);
    repeat (4) @(negedge clk);
    arm(1, 1550, 20, 1'b1);
    send(8'hD0, 4, 6, 0, 1'b1, 1'b0, 0, 1, 4, 1'b0);        // R7 same slot resumes
    arm(2, 7, 6, 1'b1);
    send(8'hE0, 9, 0, 3, 1'b0, 1'b1, 1, 2, 7, 1'b0);        // R6 R10 mid-word clamp
    drv_done = 1'b1;
  end

  // monitor / scoreboard: sole owner of the counters
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(int i, int k);
    return mem[buf_word(i) + k / 4][8 * (k % 4) +: 8];
  endfunction

  initial begin
    exp_t e;
    int   wd, bad, dix;
    wd = 0;
    @(negedge clk);
    chk(!in_ready && !mem_req && !rx_done && !rx_err, "R9", "idle outputs in reset",
        {28'h0, in_ready, mem_req, rx_done, rx_err}, 32'h0);
    while (!(drv_done && q.size() == 0) && wd < 100000) begin
      @(negedge clk);
      wd++;
      if (q.size() > 0 && q[0].kind == 2) begin
        e = q.pop_front();
        dix = RING + e.idx * 4;
        chk(mem[dix][31] == 1'b0 && mem[dix + 3] == 32'h0, "R7",
            "unowned descriptor untouched", mem[dix + 3], 32'h0);
        chk(mem[buf_word(e.idx)] == 32'hEEEE_EEEE, "R7", "no buffer write on drop",
            mem[buf_word(e.idx)], 32'hEEEE_EEEE);
      end else if (rx_done) begin
        chk(q.size() > 0 && q[0].kind == 0, "R7", "unexpected completion",
            32'(q.size()), 32'h0);
        if (q.size() > 0) begin
          e = q.pop_front();
          @(negedge clk);
          dix = RING + e.idx * 4;
          chk(mem[dix + 3] == e.stat, "R4", "status word (R5 length)", mem[dix + 3], e.stat);
          chk(mem[dix] == e.w0, "R8", "released word 0 (R2 last flag)", mem[dix], e.w0);
          chk(rel_cyc[e.idx] == stat_cyc[e.idx] + 1, "R8", "status one cycle before release",
              32'(rel_cyc[e.idx]), 32'(stat_cyc[e.idx] + 1));
          bad = 0;
          for (int k = 0; k < e.len; k++)
            if (mbyte(e.idx, k) != 8'(e.seed + k)) bad++;
          chk(bad == 0, "R5", "buffer contents", 32'(bad), 32'h0);
          bad = 0;
          for (int k = e.len; k < e.len + 8; k++)
            if (mbyte(e.idx, k) != 8'hEE) bad++;
          chk(bad == 0, "R10", "bytes past length untouched (R6)", 32'(bad), 32'h0);
        end
      end else if (rx_err) begin
        chk(q.size() > 0 && q[0].kind == 1, "R7", "drop signalled", 32'(q.size()), 32'h1);
        if (q.size() > 0) void'(q.pop_front());
      end
    end
    if (wd >= 100000) chk(1'b0, "R1", "watchdog expired", 32'(wd), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule